// File: doc/BRIEF.md
# Return and Interrupt-Return Stack Unwinder

This block performs the stack side of two CPU operations on an 8-bit machine with 16-bit registers: returning from a subroutine and returning from an interrupt. It pops bytes one at a time from a byte-wide memory read port. It keeps its own 16-bit stack pointer, loaded from `sp_in` when a sequence is accepted. Each completed register value is handed to the register file through a single write port.

A start pulse with `ret_irq` low gives a plain return. The block waits one cycle and then pops the program counter. With `ret_irq` high, the condition-code byte is popped first. Bit 7 of that byte is the saved-everything flag. When the flag is clear, only the program counter follows. When it is set, every register follows.

When the program counter has been written, `done` pulses for one cycle.

Top module: `stack_unwind_seq`

## Requirements
- R1: A plain return (`ret_irq`=0) spends exactly one cycle with `mem_rd` low after the start is accepted. It then pops two bytes and writes the program counter from them.
- R2: Each pop drives `mem_rd`=1 with `mem_addr` equal to the current stack pointer. The stack pointer then increases by one, wrapping from 16'hFFFF to 16'h0000. When a sequence ends, `sp_out` equals the `sp_in` value accepted at start plus the number of pops, modulo 2^16.
- R3: An interrupt return (`ret_irq`=1) reads memory in the first cycle after the start is accepted. The byte it reads is written as the condition-code register, select code 0.
- R4: If bit 7 of the popped condition-code byte is 0, the next pop is the upper byte of the program counter. The whole sequence then makes exactly 3 reads.
- R5: If bit 7 of the popped condition-code byte is 1, the write order is: condition codes (0), A (1), B (2), direct page (3), X (4), Y (5), U (6), program counter (7). The sequence makes exactly 12 reads.
- R6: A 16-bit register takes two successive pops, and the first byte popped becomes bits 15:8. An 8-bit register is written zero-extended to 16 bits.
- R7: Each register is written with `wr_en`=1 for one cycle. That cycle is the one after its last byte was read, and `wr_sel` carries the select code.
- R8: `done` is high for exactly one cycle, the cycle right after the program-counter write.
- R9: A start pulse that arrives while a sequence is running, up to the cycle before `done`, is ignored. It does not change the reads, the writes or the stack pointer.
- R10: After reset, `mem_rd`, `wr_en` and `done` are low and no sequence is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Starts a sequence when idle |
| ret_irq | input | 1 | 1 = interrupt return, 0 = plain return |
| sp_in | input | 16 | Stack pointer value taken at start |
| mem_rd | output | 1 | Memory read strobe, one per pop |
| mem_addr | output | 16 | Read address (current stack pointer) |
| mem_rdata | input | 8 | Read data, valid in the same cycle as `mem_rd` |
| sp_out | output | 16 | Current stack pointer |
| wr_en | output | 1 | Register-file write strobe |
| wr_sel | output | 3 | Register select code (0 CC … 7 PC) |
| wr_data | output | 16 | Register value |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions check several rules on every cycle:
- every pop advances the stack pointer by exactly one;
- the upper half of each 16-bit write matches the byte read two cycles earlier;
- `done` always follows a program-counter write;
- a clear saved-everything flag sends the very next pop to the program counter;
- a reload never coincides with a pop.

Only the bench's scenarios can show the rest. That covers the full ordering of the twelve pops, the exact read counts for each path, the one-cycle gap of a plain return, wrap-around at the top of memory, and that a start pulse in mid-sequence leaves the traffic untouched.

// File: rtl/spull_pkg.sv
package spull_pkg;

    localparam int ADDR_W     = 16;
    localparam int BYTE_W     = 8;
    localparam int WORD_W     = 2 * BYTE_W;
    localparam int NUM_STEPS  = 12;
    localparam int STEP_W     = $clog2(NUM_STEPS);
    localparam int ESTATE_BIT = BYTE_W - 1;

    localparam logic [STEP_W-1:0] STEP_CC    = '0;
    localparam logic [STEP_W-1:0] STEP_PC_HI = STEP_W'(NUM_STEPS - 2);
    localparam logic [STEP_W-1:0] STEP_LAST  = STEP_W'(NUM_STEPS - 1);

    typedef enum logic [2:0] {
        RG_CC = 3'd0,
        RG_A  = 3'd1,
        RG_B  = 3'd2,
        RG_DP = 3'd3,
        RG_X  = 3'd4,
        RG_Y  = 3'd5,
        RG_U  = 3'd6,
        RG_PC = 3'd7
    } reg_id_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_GAP,
        ST_POP,
        ST_FIN
    } seq_st_e;

    typedef struct packed {
        reg_id_e id;
        logic    wide;
        logic    low;
    } pop_slot_t;

    function automatic pop_slot_t slot_of(input logic [STEP_W-1:0] s);
        pop_slot_t r;
        case (s)
            4'd0:    r = '{id: RG_CC, wide: 1'b0, low: 1'b1};
            4'd1:    r = '{id: RG_A,  wide: 1'b0, low: 1'b1};
            4'd2:    r = '{id: RG_B,  wide: 1'b0, low: 1'b1};
            4'd3:    r = '{id: RG_DP, wide: 1'b0, low: 1'b1};
            4'd4:    r = '{id: RG_X,  wide: 1'b1, low: 1'b0};
            4'd5:    r = '{id: RG_X,  wide: 1'b1, low: 1'b1};
            4'd6:    r = '{id: RG_Y,  wide: 1'b1, low: 1'b0};
            4'd7:    r = '{id: RG_Y,  wide: 1'b1, low: 1'b1};
            4'd8:    r = '{id: RG_U,  wide: 1'b1, low: 1'b0};
            4'd9:    r = '{id: RG_U,  wide: 1'b1, low: 1'b1};
            4'd10:   r = '{id: RG_PC, wide: 1'b1, low: 1'b0};
            default: r = '{id: RG_PC, wide: 1'b1, low: 1'b1};
        endcase
        return r;
    endfunction

    function automatic logic is_wide_id(input logic [2:0] id);
        return id >= 3'(RG_X);
    endfunction

endpackage

// File: rtl/spull_ctrl.sv
module spull_ctrl
    import spull_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      start,
    input  logic      ret_irq,
    input  logic      es_flag,
    output logic      busy,
    output logic      pop,
    output logic      load,
    output logic      done,
    output pop_slot_t slot
);

    seq_st_e           state_q;
    logic [STEP_W-1:0] step_q;

    assign busy = (state_q != ST_IDLE);
    assign pop  = (state_q == ST_POP);
    assign load = start && (state_q == ST_IDLE);
    assign slot = slot_of(step_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            step_q  <= '0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        if (ret_irq) begin
                            state_q <= ST_POP;
                            step_q  <= STEP_CC;
                        end else begin
                            state_q <= ST_GAP;
                        end
                    end
                end
                ST_GAP: begin
                    state_q <= ST_POP;
                    step_q  <= STEP_PC_HI;
                end
                ST_POP: begin
                    if (step_q == STEP_LAST) begin
                        state_q <= ST_FIN;
                    end else if (step_q == STEP_CC && !es_flag) begin
                        step_q <= STEP_PC_HI;
                    end else begin
                        step_q <= step_q + 1'b1;
                    end
                end
                ST_FIN: begin
                    done    <= 1'b1;
                    state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R10: leaving reset, nothing is running
    a_r10_idle_after_reset: assert property (@(posedge clk)
        rst |=> (!busy && !done));

    // R1: the cycle after the gap is always a pop
    a_r1_gap_then_pop: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_GAP) |=> pop);

endmodule

// File: rtl/spull_sp.sv
module spull_sp
    import spull_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_val,
    input  logic              inc,
    output logic [ADDR_W-1:0] sp
);

    always_ff @(posedge clk) begin
        if (rst) begin
            sp <= '0;
        end else if (load) begin
            sp <= load_val;
        end else if (inc) begin
            sp <= sp + 1'b1;
        end
    end

    // R2: every pop advances the pointer by one, modulo 2^16
    a_r2_sp_step: assert property (@(posedge clk) disable iff (rst)
        inc |=> (sp == ADDR_W'($past(sp) + 1'b1)));

    // R9: a reload never happens in a pop cycle
    a_r9_no_reload_mid: assert property (@(posedge clk) disable iff (rst)
        inc |-> !load);

endmodule

// File: rtl/spull_join.sv
module spull_join
    import spull_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              pop,
    input  pop_slot_t         slot,
    input  logic [BYTE_W-1:0] rdata,
    output logic              wr_en,
    output logic [2:0]        wr_sel,
    output logic [WORD_W-1:0] wr_data
);

    logic [BYTE_W-1:0] hi_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_q    <= '0;
            wr_en   <= 1'b0;
            wr_sel  <= '0;
            wr_data <= '0;
        end else begin
            wr_en <= 1'b0;
            if (pop) begin
                if (slot.wide && !slot.low) begin
                    hi_q <= rdata;
                end else begin
                    wr_en   <= 1'b1;
                    wr_sel  <= slot.id;
                    wr_data <= slot.wide ? {hi_q, rdata}
                                         : {{(WORD_W-BYTE_W){1'b0}}, rdata};
                end
            end
        end
    end

    // R6: the upper half of a wide value is the byte read two cycles earlier
    a_r6_upper_first: assert property (@(posedge clk) disable iff (rst)
        (wr_en && is_wide_id(wr_sel)) |-> (wr_data[WORD_W-1:BYTE_W] == $past(rdata, 2)));

    // R7: a write always follows a read in the previous cycle
    a_r7_write_after_read: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> $past(pop));

endmodule

// File: rtl/stack_unwind_seq.sv
module stack_unwind_seq
    import spull_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              ret_irq,
    input  logic [ADDR_W-1:0] sp_in,
    output logic              mem_rd,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [BYTE_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] sp_out,
    output logic              wr_en,
    output logic [2:0]        wr_sel,
    output logic [WORD_W-1:0] wr_data,
    output logic              done
);

    logic      busy;
    logic      load;
    pop_slot_t slot;

    spull_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .ret_irq (ret_irq),
        .es_flag (mem_rdata[ESTATE_BIT]),
        .busy    (busy),
        .pop     (mem_rd),
        .load    (load),
        .done    (done),
        .slot    (slot)
    );

    spull_sp u_sp (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .load_val (sp_in),
        .inc      (mem_rd),
        .sp       (sp_out)
    );

    spull_join u_join (
        .clk     (clk),
        .rst     (rst),
        .pop     (mem_rd),
        .slot    (slot),
        .rdata   (mem_rdata),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data)
    );

    assign mem_addr = sp_out;

    // R8: done comes only right after the program-counter write
    a_r8_done_after_pc: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(wr_en) && $past(wr_sel) == 3'(RG_PC)));

    // R4: a clear saved-everything flag sends the next pop to the PC upper byte
    a_r4_short_skip: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == 3'(RG_CC) && !wr_data[ESTATE_BIT])
            |-> (mem_rd && slot.id == RG_PC && !slot.low));

    // R8: done and a read are never both active
    a_r8_done_quiet: assert property (@(posedge clk) disable iff (rst)
        $onehot0({done, mem_rd, busy && done}));

endmodule

// File: tb/stack_unwind_seq_bench.sv
module stack_unwind_seq_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic        ret_irq;
    logic [15:0] sp_in;
    logic        mem_rd;
    logic [15:0] mem_addr;
    logic [7:0]  mem_rdata;
    logic [15:0] sp_out;
    logic        wr_en;
    logic [2:0]  wr_sel;
    logic [15:0] wr_data;
    logic        done;

    always #4 clk = ~clk;

    int checks = 0;
    int fails  = 0;

    logic [15:0] cc_addr = 16'h0;
    logic [7:0]  cc_val  = 8'h0;
    logic        cc_en   = 1'b0;

    function automatic logic [7:0] mem_at(input logic [15:0] a);
        if (cc_en && a == cc_addr) return cc_val;
        return 8'((a[7:0] * 8'd3) ^ a[15:8] ^ 8'hA5);
    endfunction

    assign mem_rdata = mem_at(mem_addr);

    stack_unwind_seq u_stack_unwind_seq (
        .clk(clk), .rst(rst), .start(start), .ret_irq(ret_irq), .sp_in(sp_in),
        .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .sp_out(sp_out), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .done(done)
    );

    logic [15:0] exp_rd[$];
    logic [18:0] exp_wr[$];
    logic        prev_pc_wr = 1'b0;

    task automatic chk(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor: compares design traffic against the scoreboard queues
    always @(negedge clk) begin
        if (!rst) begin
            if (mem_rd) begin
                if (exp_rd.size() == 0) chk(1'b0, "R2 unexpected read", 32'(mem_addr), 0);
                else begin
                    logic [15:0] e;
                    e = exp_rd.pop_front();
                    chk(mem_addr == e, "R2 read address", 32'(mem_addr), 32'(e));
                end
            end
            if (wr_en) begin
                if (exp_wr.size() == 0) chk(1'b0, "R5 unexpected write", {13'd0, wr_sel, wr_data}, 0);
                else begin
                    logic [18:0] e;
                    e = exp_wr.pop_front();
                    chk({wr_sel, wr_data} == e, "R6 R7 write sel/data",
                        {13'd0, wr_sel, wr_data}, {13'd0, e});
                end
            end
            if (done) chk(prev_pc_wr, "R8 done after PC write", 32'(prev_pc_wr), 1);
            prev_pc_wr <= wr_en && wr_sel == 3'd7;
        end
    end

    // driver: builds expectations, starts a sequence, waits for done
    task automatic run(input logic irq, input logic [15:0] sp0, input logic [7:0] ccv,
                       input logic poke_start);
        int n = 0;
        int guard = 0;
        logic [15:0] p = sp0;
        cc_en   = irq;
        cc_addr = sp0;
        cc_val  = ccv;
        if (irq) begin
            exp_rd.push_back(p); exp_wr.push_back({3'd0, 8'h00, ccv}); p++; n++;
            if (ccv[7]) begin
                for (int r = 1; r <= 3; r++) begin
                    exp_rd.push_back(p); exp_wr.push_back({3'(r), 8'h00, mem_at(p)}); p++; n++;
                end
                for (int r = 4; r <= 6; r++) begin
                    logic [15:0] w;
                    w = {mem_at(p), mem_at(16'(p + 1))};
                    exp_rd.push_back(p); exp_rd.push_back(16'(p + 1));
                    exp_wr.push_back({3'(r), w}); p = 16'(p + 2); n += 2;
                end
            end
        end
        exp_rd.push_back(p); exp_rd.push_back(16'(p + 1));
        exp_wr.push_back({3'd7, mem_at(p), mem_at(16'(p + 1))});
        p = 16'(p + 2); n += 2;

        @(negedge clk);
        start = 1'b1; ret_irq = irq; sp_in = sp0;
        @(negedge clk);
        start = 1'b0; sp_in = 16'h1234; ret_irq = ~irq;
        if (irq) chk(mem_rd == 1'b1, "R3 first cycle reads CC", 32'(mem_rd), 1);
        else     chk(mem_rd == 1'b0, "R1 idle cycle before pops", 32'(mem_rd), 0);
        if (poke_start) begin
            @(negedge clk);
            start = 1'b1; // R9: must be ignored
            @(negedge clk);
            start = 1'b0;
        end
        while (!done && guard < 100) begin
            @(negedge clk);
            guard++;
        end
        chk(guard < 100, "watchdog", 32'(guard), 0);
        @(negedge clk);
        chk(done == 1'b0, "R8 done one cycle", 32'(done), 0);
        chk(exp_rd.size() == 0, irq ? (ccv[7] ? "R5 read count" : "R4 read count")
                                    : "R1 read count", 32'(exp_rd.size()), 0);
        chk(exp_wr.size() == 0, "R7 all writes seen", 32'(exp_wr.size()), 0);
        chk(sp_out == p, "R2 final stack pointer", 32'(sp_out), 32'(p));
        exp_rd.delete(); exp_wr.delete();
    endtask

    initial begin
        rst = 1'b1; start = 1'b0; ret_irq = 1'b0; sp_in = 16'h0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R10: reset state
        chk(!mem_rd && !wr_en && !done, "R10 reset outputs", {29'd0, mem_rd, wr_en, done}, 0);
        run(1'b0, 16'h0200, 8'h00, 1'b0);   // R1 plain return
        run(1'b1, 16'h0300, 8'h45, 1'b0);   // R4 short interrupt return
        run(1'b1, 16'h0400, 8'hC3, 1'b0);   // R5 full interrupt return
        run(1'b0, 16'hFFFF, 8'h00, 1'b0);   // R2 wrap on plain return
        run(1'b1, 16'hFFF8, 8'h80, 1'b0);   // R2 R5 wrap during full pull
        run(1'b1, 16'h0500, 8'hFF, 1'b1);   // R9 start during full pull ignored
        run(1'b0, 16'h0600, 8'h00, 1'b1);   // R9 start during plain return ignored
        repeat (3) @(negedge clk);
        chk(!wr_en && !mem_rd, "R9 no stray sequence", {30'd0, wr_en, mem_rd}, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule